// File: doc/BRIEF.md
# Program Counter Steering and Trap Capture

This block holds the program counter of a 32-bit multi-cycle processor and chooses the value the counter takes next. It picks from four candidates. The first is the live arithmetic result, which is the sequential address during fetch. The second is the held arithmetic result, which carries a computed branch target. The third is a region-relative jump target, built from the top bits of the current counter and a 26-bit instruction field scaled to a word address. The fourth is a fixed trap vector. The counter loads on an unconditional enable, or on a conditional enable when the arithmetic zero flag is set. In every other cycle it keeps its value.

The block also records fault state when the sequencer reports a fault. The fault-address register takes the current counter minus one instruction width. The counter has already moved past the faulting instruction during fetch, so this recovers that instruction's address. The fault-reason register takes a code of 0 for an undecodable instruction or 1 for an arithmetic overflow. Both capture registers are written on their own enables, independently of the counter update.

Top module: `nextpc_excp`

## Requirements
- R1: While rst_n is low, pc_q, epc_q and cause_q are all zero. Reset acts asynchronously.
- R2: With sel_src = 2'b00 and a load taking place, pc_q takes alu_res at the next rising edge.
- R3: With sel_src = 2'b01 and a load taking place, pc_q takes alu_hold at the next rising edge.
- R4: With sel_src = 2'b10 and a load taking place, pc_q takes {pc_q[31:28], instr_tgt[25:0], 2'b00}. The top four bits come from the counter value before the edge.
- R5: With sel_src = 2'b11 and a load taking place, pc_q takes 32'hC000_0000.
- R6: When ld_pc_if_zero is 1 and ld_pc is 0, pc_q loads only if alu_zero is 1. If alu_zero is 0, pc_q holds.
- R7: When ld_pc and ld_pc_if_zero are both 0, pc_q holds, whatever the other inputs are.
- R8: When ld_epc is 1, epc_q takes the value pc_q had before the edge, minus 4. This holds even if pc_q changes at the same edge. When ld_epc is 0, epc_q holds.
- R9: When ld_cause is 1, cause_q takes 32'd1 if cause_is_ovf is 1 and 32'd0 if it is 0. When ld_cause is 0, cause_q holds.
- R10: The subtraction for epc_q wraps modulo 2^32, so a pc_q of 0 gives epc_q = 32'hFFFF_FFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | 32 | Live arithmetic result (sequential address during fetch) |
| alu_hold | input | 32 | Held arithmetic result (branch target) |
| instr_tgt | input | 26 | Low 26 bits of the instruction register |
| sel_src | input | 2 | Next-counter source select |
| ld_pc | input | 1 | Unconditional counter load |
| ld_pc_if_zero | input | 1 | Counter load qualified by alu_zero |
| alu_zero | input | 1 | Arithmetic zero flag |
| ld_epc | input | 1 | Fault-address register load |
| ld_cause | input | 1 | Fault-reason register load |
| cause_is_ovf | input | 1 | Fault reason: 1 overflow, 0 undecodable instruction |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Fault address |
| cause_q | output | 32 | Fault reason code |

## Verification
The bench sweeps every combination of source select, the two load enables, the zero flag and the three capture controls, and repeats the sweep over several data patterns. Some patterns drive the counter back to zero. That case covers the wrap of the fault address. An unsigned compare or a missing modulo would leave some value other than 32'hFFFF_FFFC.

The sweep also covers a fault-address load on the same edge as a counter redirect. A design that sampled the new counter there would record the redirected address instead of the faulting one. Conditional loads with the zero flag clear show whether a design treats the conditional enable as unconditional. Jump cases check the region bits, which must come from the counter value before the edge. A final mid-cycle reset checks that clearing does not wait for a clock edge.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2,
    SRC_TRAP   = 2'd3
  } pc_src_e;

  typedef struct packed {
    logic ld_epc;
    logic ld_cause;
    logic is_ovf;
  } trap_ctl_t;

endpackage

// File: rtl/nextpc_sel.sv
module nextpc_sel
  import nextpc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          TGT_W    = 26,
  parameter int          WORD_SH  = 2,
  parameter logic [31:0] TRAP_VEC = 32'hC000_0000
) (
  input  logic [XLEN-1:0]  alu_res,
  input  logic [XLEN-1:0]  alu_hold,
  input  logic [TGT_W-1:0] instr_tgt,
  input  logic [XLEN-1:0]  pc_q,
  input  logic [1:0]       sel_src,
  output logic [XLEN-1:0]  next_pc
);

  localparam int REGION_W = XLEN - TGT_W - WORD_SH;
  localparam logic [XLEN-1:0] VEC = XLEN'(TRAP_VEC);

  logic [XLEN-1:0] jump_pc;

  // Region-relative jump: keep the current region, place the scaled field below it.
  generate
    if (REGION_W > 0) begin : g_region
      assign jump_pc = {pc_q[XLEN-1 -: REGION_W], instr_tgt, {WORD_SH{1'b0}}};
    end else begin : g_flat
      assign jump_pc = XLEN'({instr_tgt, {WORD_SH{1'b0}}});
    end
  endgenerate

  always_comb begin
    unique case (pc_src_e'(sel_src))
      SRC_SEQ:    next_pc = alu_res;
      SRC_BRANCH: next_pc = alu_hold;
      SRC_JUMP:   next_pc = jump_pc;
      SRC_TRAP:   next_pc = VEC;
      default:    next_pc = alu_res;
    endcase
  end

endmodule

// File: rtl/nextpc_pcreg.sv
module nextpc_pcreg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] next_pc,
  input  logic            ld_pc,
  input  logic            ld_pc_if_zero,
  input  logic            alu_zero,
  output logic [XLEN-1:0] pc_q
);

  logic            pc_en;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    pc_en = ld_pc | (ld_pc_if_zero & alu_zero);
    pc_d  = pc_en ? next_pc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/nextpc_trapreg.sv
module nextpc_trapreg
  import nextpc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    pc_q,
  input  trap_ctl_t          ctl,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0]    epc_d;
  logic [CAUSE_W-1:0] code;
  logic [CAUSE_W-1:0] cause_d;

  generate
    if (CAUSE_W > 1) begin : g_wide
      assign code = {{(CAUSE_W-1){1'b0}}, ctl.is_ovf};
    end else begin : g_bit
      assign code = ctl.is_ovf;
    end
  endgenerate

  always_comb begin
    epc_d   = ctl.ld_epc   ? (pc_q - STEP) : epc_q;
    cause_d = ctl.ld_cause ? code          : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/nextpc_excp.sv
module nextpc_excp
  import nextpc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          TGT_W       = 26,
  parameter int          WORD_SH     = 2,
  parameter int          CAUSE_W     = 32,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] TRAP_VEC    = 32'hC000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    alu_res,
  input  logic [XLEN-1:0]    alu_hold,
  input  logic [TGT_W-1:0]   instr_tgt,
  input  logic [1:0]         sel_src,
  input  logic               ld_pc,
  input  logic               ld_pc_if_zero,
  input  logic               alu_zero,
  input  logic               ld_epc,
  input  logic               ld_cause,
  input  logic               cause_is_ovf,
  output logic [XLEN-1:0]    pc_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);

  logic [XLEN-1:0] next_pc;
  trap_ctl_t       tctl;

  assign tctl = '{ld_epc: ld_epc, ld_cause: ld_cause, is_ovf: cause_is_ovf};

  nextpc_sel #(
    .XLEN(XLEN), .TGT_W(TGT_W), .WORD_SH(WORD_SH), .TRAP_VEC(TRAP_VEC)
  ) u_sel (
    .alu_res   (alu_res),
    .alu_hold  (alu_hold),
    .instr_tgt (instr_tgt),
    .pc_q      (pc_q),
    .sel_src   (sel_src),
    .next_pc   (next_pc)
  );

  nextpc_pcreg #(.XLEN(XLEN)) u_pc (
    .clk           (clk),
    .rst_n         (rst_n),
    .next_pc       (next_pc),
    .ld_pc         (ld_pc),
    .ld_pc_if_zero (ld_pc_if_zero),
    .alu_zero      (alu_zero),
    .pc_q          (pc_q)
  );

  nextpc_trapreg #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_q    (pc_q),
    .ctl     (tctl),
    .epc_q   (epc_q),
    .cause_q (cause_q)
  );

endmodule

// File: rtl/nextpc_excp_chk.sv
module nextpc_excp_chk #(
  parameter int          XLEN     = 32,
  parameter int          CAUSE_W  = 32,
  parameter logic [31:0] TRAP_VEC = 32'hC000_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         sel_src,
  input logic               ld_pc,
  input logic               ld_pc_if_zero,
  input logic               alu_zero,
  input logic               ld_epc,
  input logic               ld_cause,
  input logic               cause_is_ovf,
  input logic [XLEN-1:0]    pc_q,
  input logic [XLEN-1:0]    epc_q,
  input logic [CAUSE_W-1:0] cause_q
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pc && !ld_pc_if_zero) |=> $stable(pc_q)); // R7

  AST_COND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pc && ld_pc_if_zero && !alu_zero) |=> $stable(pc_q)); // R6

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc && sel_src == 2'b11) |=> (pc_q == XLEN'(TRAP_VEC))); // R5

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc && sel_src == 2'b10) |=>
      (pc_q[XLEN-1 -: 4] == $past(pc_q[XLEN-1 -: 4]) && pc_q[1:0] == 2'b00)); // R4

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_epc |=> (epc_q == $past(pc_q) - XLEN'(4))); // R8

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_epc |=> $stable(epc_q)); // R8

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cause |=> (cause_q == CAUSE_W'($past(cause_is_ovf)))); // R9

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cause |=> $stable(cause_q)); // R9

endmodule

bind nextpc_excp nextpc_excp_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_src       (sel_src),
  .ld_pc         (ld_pc),
  .ld_pc_if_zero (ld_pc_if_zero),
  .alu_zero      (alu_zero),
  .ld_epc        (ld_epc),
  .ld_cause      (ld_cause),
  .cause_is_ovf  (cause_is_ovf),
  .pc_q          (pc_q),
  .epc_q         (epc_q),
  .cause_q       (cause_q)
);

// File: tb/nextpc_excp_test.sv
`timescale 1ns/1ps
module nextpc_excp_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] alu_res, alu_hold;
  logic [25:0] instr_tgt;
  logic [1:0]  sel_src;
  logic        ld_pc, ld_pc_if_zero, alu_zero;
  logic        ld_epc, ld_cause, cause_is_ovf;
  logic [31:0] pc_q, epc_q, cause_q;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  nextpc_excp uut (
    .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_hold(alu_hold),
    .instr_tgt(instr_tgt), .sel_src(sel_src), .ld_pc(ld_pc),
    .ld_pc_if_zero(ld_pc_if_zero), .alu_zero(alu_zero), .ld_epc(ld_epc),
    .ld_cause(ld_cause), .cause_is_ovf(cause_is_ovf),
    .pc_q(pc_q), .epc_q(epc_q), .cause_q(cause_q)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_pc, e_epc, e_cause;
    rst_n = 1'b0; alu_res = '0; alu_hold = '0; instr_tgt = '0; sel_src = '0;
    ld_pc = 0; ld_pc_if_zero = 0; alu_zero = 0; ld_epc = 0; ld_cause = 0; cause_is_ovf = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pc_q", pc_q, 32'h0);
    check("R1", "epc_q", epc_q, 32'h0);
    check("R1", "cause_q", cause_q, 32'h0);
    rst_n = 1'b1;
    e_pc = '0; e_epc = '0; e_cause = '0;

    for (int pat = 0; pat < 12; pat++) begin
      for (int src = 0; src < 4; src++) begin
        for (int en = 0; en < 8; en++) begin
          for (int ex = 0; ex < 8; ex++) begin
            logic [31:0] a, n_pc, n_epc, n_cause;
            logic        load;
            string       ptag, etag;
            a = (32'h9E37_79B9 * 32'(pat + 1)) ^ 32'(src * 32'h1111_0000 + en * 8 + ex);
            alu_res       = (pat % 3 == 0) ? 32'h0 : a;
            alu_hold      = {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
            instr_tgt     = 26'(a >> 3);
            sel_src       = 2'(src);
            ld_pc         = en[2];
            ld_pc_if_zero = en[1];
            alu_zero      = en[0];
            ld_epc        = ex[2];
            ld_cause      = ex[1];
            cause_is_ovf  = ex[0];
            load = ld_pc | (ld_pc_if_zero & alu_zero);
            case (src)
              0: begin n_pc = alu_res;  ptag = "R2"; end
              1: begin n_pc = alu_hold; ptag = "R3"; end
              2: begin n_pc = {e_pc[31:28], instr_tgt, 2'b00}; ptag = "R4"; end
              default: begin n_pc = 32'hC000_0000; ptag = "R5"; end
            endcase
            if (!load) begin
              n_pc = e_pc;
              ptag = ld_pc_if_zero ? "R6" : "R7";
            end else if (!ld_pc) begin
              ptag = "R6";
            end
            etag    = (e_pc == 32'h0) ? "R10" : "R8";
            n_epc   = ld_epc ? (e_pc - 32'd4) : e_epc;
            n_cause = ld_cause ? {31'b0, cause_is_ovf} : e_cause;
            @(negedge clk);
            check(ptag, "pc_q", pc_q, n_pc);
            check(etag, "epc_q", epc_q, n_epc);
            check("R9", "cause_q", cause_q, n_cause);
            e_pc = n_pc; e_epc = n_epc; e_cause = n_cause;
          end
        end
      end
    end

    // R1: asynchronous clear mid-cycle
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", "pc_q async", pc_q, 32'h0);
    check("R1", "epc_q async", epc_q, 32'h0);
    check("R1", "cause_q async", cause_q, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule